// File: doc/BRIEF.md
# Magnitude-Capable Adder-Subtractor

This block is an 8-bit adder-subtractor assembled from single-bit full-adder cells chained in ripple fashion. A two-bit mode input picks the operation. In the subtract modes the second operand is inverted bitwise and the chain's carry-in is tied high, so the chain computes A plus the two's complement of B. In this form a carry-out of 1 means A is not smaller than B. A carry-out of 0 means the true difference is negative.

One mode uses that carry-out as a sign bit. When the difference is negative, the raw sum is passed through a second ripple chain that two's-complements it, so the output is the magnitude |A-B|. This is the operation an image datapath uses to find the distance between two pixel gray values. A separate negative flag reports the sign. The block is purely combinational, with no clock, no reset and no handshake. The outputs follow the inputs within the same cycle, and the block is meant to sit inside a registered pipeline stage of the enclosing design.

Top module: `absdiff_addsub`

## Requirements
- R1: With mode 0 or mode 1, `sum_o` is the low 8 bits of A+B and `carry_o` is bit 8 of A+B.
- R2: With mode 3, `sum_o` is (A-B) modulo 256, with no correction applied, and `carry_o` is 1 exactly when A >= B.
- R3: With mode 2, `sum_o` is |A-B|, and `carry_o` is 1 exactly when A >= B.
- R4: `neg_o` is 1 exactly when bit 1 of the mode is 1 (mode 2 or 3) and A < B. It is 0 in modes 0 and 1 for every operand pair.
- R5: In mode 2 or mode 3, equal operands give `sum_o` = 0, `neg_o` = 0 and `carry_o` = 1.
- R6: The extremes are handled without wrap errors. In mode 2, operands 0 and 255 in either order give 255. In mode 3, A=0 and B=1 give 255 with `neg_o` = 1.
- R7: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 8 | First operand (minuend in subtract modes) |
| op_b_i | input | 8 | Second operand (subtrahend in subtract modes) |
| mode_i | input | 2 | 0/1 add, 2 magnitude of difference, 3 raw difference |
| sum_o | output | 8 | Sum, raw difference or magnitude |
| carry_o | output | 1 | Carry-out of the primary ripple chain |
| neg_o | output | 1 | High when a subtract mode sees A < B |

## Verification
Two functions act together whenever mode 2 meets A < B. In that case the borrow detection on the primary chain must raise `neg_o`, and in the same evaluation the correction chain must negate the raw result. The bench provokes this with operand pairs at the sign boundary: B = A+1, B = 255 with A = 0, and strided sweeps where B exceeds A. Each case is judged by comparing `sum_o`, `neg_o` and `carry_o` together against an integer model of |A-B|, so a fault in either function, or in their hand-off, shows up as a mismatch.

// File: rtl/absdiff_pkg.sv
package absdiff_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ADD0   = 2'd0,
    MODE_ADD1   = 2'd1,
    MODE_MAGN   = 2'd2,
    MODE_RAWSUB = 2'd3
  } absdiff_mode_e;

  function automatic logic is_sub(input logic [MODE_W-1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/absd_full_adder.sv
module absd_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic xy;
  always_comb begin
    xy  = x_i ^ y_i;
    s_o = xy ^ c_i;
    c_o = (x_i & y_i) | (xy & c_i);
  end
endmodule

// File: rtl/absd_ripple_adder.sv
module absd_ripple_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] chain;

  always_comb chain[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    absd_full_adder u_fa (
      .x_i (x_i[k]),
      .y_i (y_i[k]),
      .c_i (chain[k]),
      .s_o (sum_o[k]),
      .c_o (chain[k+1])
    );
  end

  always_comb cout_o = chain[WIDTH];
endmodule

// File: rtl/absd_cond_negate.sv
module absd_cond_negate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             neg_en_i,
  output logic [WIDTH-1:0] val_o
);
  logic [WIDTH-1:0] flipped;
  logic [WIDTH-1:0] negated;
  logic             unused_cout;

  always_comb flipped = val_i ^ {WIDTH{neg_en_i}};

  absd_ripple_adder #(.WIDTH(WIDTH)) u_inc (
    .x_i    (flipped),
    .y_i    ('0),
    .cin_i  (neg_en_i),
    .sum_o  (negated),
    .cout_o (unused_cout)
  );

  always_comb val_o = negated;
endmodule

// File: rtl/absdiff_addsub.sv
module absdiff_addsub
  import absdiff_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0]  op_a_i,
  input  logic [WIDTH-1:0]  op_b_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [WIDTH-1:0]  sum_o,
  output logic              carry_o,
  output logic              neg_o
);
  logic             sub_en;
  logic             magn_en;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] raw_sum;
  logic             raw_cout;
  logic             borrow;

  always_comb begin
    sub_en  = is_sub(mode_i);
    magn_en = (mode_i == MODE_MAGN);
    b_eff   = op_b_i ^ {WIDTH{sub_en}};
  end

  absd_ripple_adder #(.WIDTH(WIDTH)) u_main (
    .x_i    (op_a_i),
    .y_i    (b_eff),
    .cin_i  (sub_en),
    .sum_o  (raw_sum),
    .cout_o (raw_cout)
  );

  always_comb borrow = sub_en & ~raw_cout;

  absd_cond_negate #(.WIDTH(WIDTH)) u_fix (
    .val_i    (raw_sum),
    .neg_en_i (borrow & magn_en),
    .val_o    (sum_o)
  );

  always_comb begin
    carry_o = raw_cout;
    neg_o   = borrow;
  end

  // Port-level checks against integer arithmetic
  always_comb begin
    if (!mode_i[1]) begin
      assert_add_R1: assert ({carry_o, sum_o} == ({1'b0, op_a_i} + {1'b0, op_b_i}))
        else $error("R1 add mismatch");
    end
    if (mode_i == MODE_RAWSUB) begin
      assert_rawsub_R2: assert (sum_o == WIDTH'(op_a_i - op_b_i) && carry_o == (op_a_i >= op_b_i))
        else $error("R2 raw difference mismatch");
    end
    if (mode_i == MODE_MAGN) begin
      assert_magn_R3: assert (sum_o == ((op_a_i >= op_b_i) ? WIDTH'(op_a_i - op_b_i)
                                                           : WIDTH'(op_b_i - op_a_i)))
        else $error("R3 magnitude mismatch");
    end
    assert_negflag_R4: assert (neg_o == (mode_i[1] && (op_a_i < op_b_i)))
      else $error("R4 negative flag mismatch");
    if (mode_i[1] && op_a_i == op_b_i) begin
      assert_equal_R5: assert (sum_o == '0 && !neg_o && carry_o)
        else $error("R5 equal operand mismatch");
    end
  end
endmodule

// File: tb/absdiff_addsub_tb_top.sv
module absdiff_addsub_tb_top;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [1:0] m;
  logic [7:0] sum;
  logic       cy, ng;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #4 clk = ~clk;

  absdiff_addsub dut_i (
    .op_a_i (a), .op_b_i (b), .mode_i (m),
    .sum_o (sum), .carry_o (cy), .neg_o (ng)
  );

  task automatic check(input string tag, input int ea, input int eb, input int em,
                       input logic [7:0] es, input logic ec, input logic en);
    n_chk++;
    if (sum !== es || cy !== ec || ng !== en) begin
      n_err++;
      $display("FAIL %s a=%0d b=%0d m=%0d: got sum=%0d c=%0b n=%0b exp sum=%0d c=%0b n=%0b",
               tag, ea, eb, em, sum, cy, ng, es, ec, en);
    end
  endtask

  task automatic apply_and_check(input string tag, input int ia, input int ib, input int im);
    int d;
    logic [7:0] es;
    logic ec, en;
    @(negedge clk);
    a = 8'(ia); b = 8'(ib); m = 2'(im);
    #2;
    if (im < 2) begin
      es = 8'(ia + ib); ec = ((ia + ib) > 255); en = 1'b0;
    end else begin
      d  = ia - ib;
      ec = (d >= 0);
      en = (d < 0);
      if (im == 3) es = 8'(d + 256);
      else         es = 8'((d < 0) ? -d : d);
    end
    check(tag, ia, ib, im, es, ec, en);
  endtask

  task automatic t_idle();
    @(negedge clk); a = 0; b = 0; m = 0; #2;
    check("R1 idle", 0, 0, 0, 8'd0, 1'b0, 1'b0);
  endtask

  task automatic t_add_R1();
    apply_and_check("R1", 100, 27, 0);
    apply_and_check("R1", 200, 100, 1);
    apply_and_check("R1", 255, 255, 0);
    apply_and_check("R1", 128, 128, 1);
    apply_and_check("R4 add no neg", 3, 250, 0);
  endtask

  task automatic t_rawsub_R2();
    apply_and_check("R2", 90, 30, 3);
    apply_and_check("R2", 30, 90, 3);
    apply_and_check("R2", 255, 0, 3);
  endtask

  task automatic t_magn_R3();
    apply_and_check("R3", 90, 30, 2);
    apply_and_check("R3", 30, 90, 2);
    apply_and_check("R3 R4 boundary", 77, 78, 2);
    apply_and_check("R3", 78, 77, 2);
  endtask

  task automatic t_equal_R5();
    apply_and_check("R5", 0, 0, 2);
    apply_and_check("R5", 173, 173, 3);
    apply_and_check("R5", 255, 255, 2);
  endtask

  task automatic t_extreme_R6();
    apply_and_check("R6", 0, 255, 2);
    apply_and_check("R6", 255, 0, 2);
    apply_and_check("R6", 0, 1, 3);
  endtask

  task automatic t_history_R7();
    apply_and_check("R7 first", 40, 200, 2);
    apply_and_check("R7 disturb", 255, 1, 0);
    apply_and_check("R7 disturb", 9, 250, 3);
    apply_and_check("R7 repeat", 40, 200, 2);
  endtask

  task automatic t_sweep_R4();
    for (int ia = 0; ia < 256; ia += 17)
      for (int ib = 3; ib < 256; ib += 23)
        for (int im = 0; im < 4; im++)
          apply_and_check("R4 sweep", ia, ib, im);
  endtask

  initial begin
    a = 0; b = 0; m = 0;
    repeat (2) @(posedge clk);
    t_idle();
    t_add_R1();
    t_rawsub_R2();
    t_magn_R3();
    t_equal_R5();
    t_extreme_R6();
    t_history_R7();
    t_sweep_R4();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule